// File: doc/BRIEF.md
# Block-Floating Barrel Shifter

This unit is the shift stage of a 16-bit fixed-point datapath. In one operation it places a 16-bit operand in the upper or lower half of a 32-bit field, shifts that field by a signed amount, and registers the 32-bit outcome. It also counts redundant sign bits to produce an exponent. The same hardware then normalizes a mantissa to that exponent, or denormalizes a mantissa by a given exponent.

Values wider than one word are processed one word at a time. The upper word goes first. That step records an exponent, and the lower-word step reuses it. An OR-merge control combines the new shifted word with the previously registered 32-bit result. Two 16-bit pieces therefore assemble into one 32-bit mantissa. Both the result and the exponent are registered, so either one can feed any other unit on the next cycle.

Top module: `bfp_shifter`

## Requirements
- R1: While rst_n is low, and after its release, result is 0 and exp_out is 0.
- R2: A valid operation presented before a rising clock edge changes result and exp_out at that edge and not earlier.
- R3: Placement follows hi_sel. hi_sel=1 puts operand in result bits 31:16 with zeros in 15:0. hi_sel=0 puts operand in bits 15:0 and fills bits 31:16 with zeros, or with copies of operand bit 15 when the operation is an arithmetic shift.
- R4: Opcode 0 (logical shift) uses shamt as a signed 8-bit value. A positive value shifts left and a negative value shifts right, filling with zeros. A magnitude of 32 or more gives 0.
- R5: Opcode 1 (arithmetic shift) shifts left like opcode 0. A right shift fills with copies of bit 31 of the placed field. A right magnitude of 32 or more gives 32 copies of that bit. A left amount of 32 or more gives 0.
- R6: Opcode 4 (exponent) sets exp_out to minus the count of consecutive bits below operand bit 15 that equal bit 15, giving a value from -15 to 0 (0x0000 and 0xFFFF give -15). It leaves result unchanged.
- R7: Opcode 2 with hi_sel=1 (normalize upper word) sets result to the operand in bits 31:16 shifted left by that count, and sets exp_out to minus the count. For any operand other than 0x0000 and 0xFFFF, result bit 30 then differs from bit 31.
- R8: Opcode 2 with hi_sel=0 (normalize lower word) shifts the zero-extended operand by the negation of the held exponent and leaves exp_out unchanged.
- R9: Opcode 3 with hi_sel=1 (denormalize upper word) arithmetically shifts the operand, placed in bits 31:16, by shamt, and sets exp_out to shamt.
- R10: Opcode 3 with hi_sel=0 (denormalize lower word) logically shifts the zero-extended operand by the held exponent and leaves exp_out unchanged.
- R11: For opcodes 0 to 3, or_acc=1 makes the new result the bitwise OR of the previous result and the new shifted field. With or_acc=0 the shifted field replaces the result.
- R12: Opcodes 5, 6 and 7 change neither result nor exp_out.
- R13: Opcodes 0 and 1 leave exp_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 3 | Operation select (0 logical, 1 arithmetic, 2 normalize, 3 denormalize, 4 exponent, 5-7 idle) |
| operand | input | 16 | Data word to shift or examine |
| shamt | input | 8 | Signed shift amount or exponent, positive means left |
| hi_sel | input | 1 | 1 places the operand in the upper half, 0 in the lower half |
| or_acc | input | 1 | Merge the shifted field with the previous result |
| result | output | 32 | Registered shifted field |
| exp_out | output | 8 | Registered signed exponent |

## Verification
Every operation is visible exactly one rising edge after its inputs are applied. This holds for result and for exp_out, and for the exponent held from a previous upper-word step that a lower-word step uses. The bench drives inputs on the falling edge and compares both outputs on the next falling edge, against a model it updates once per operation. One case also reads the outputs just after driving, before the edge, to confirm that nothing moves early. Sweeps cover every shift amount from -128 to 127 for several operands in both placements, and every 16-bit operand for the exponent count.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

   typedef enum logic [2:0] {
      OP_LSH    = 3'd0,
      OP_ASH    = 3'd1,
      OP_NORM   = 3'd2,
      OP_DENORM = 3'd3,
      OP_EXP    = 3'd4
   } bfs_op_e;

   localparam int BFS_STYLE_STAGED   = 0;
   localparam int BFS_STYLE_OPERATOR = 1;

endpackage

// File: rtl/bfs_place.sv
module bfs_place #(
   parameter int DW = 16
) (
   input  logic [DW-1:0]   word_i,
   input  logic            upper_i,
   input  logic            sext_i,
   output logic [2*DW-1:0] field_o
);
   localparam int RW = 2 * DW;

   logic [DW-1:0] ext_w;

   assign ext_w   = sext_i ? {DW{word_i[DW-1]}} : {DW{1'b0}};
   assign field_o = upper_i ? {word_i, {DW{1'b0}}} : {ext_w, word_i};

   if (RW != 2 * DW) begin : g_bad_rw
      $error("bfs_place: field width mismatch");
   end

endmodule

// File: rtl/bfs_signcnt.sv
module bfs_signcnt #(
   parameter int DW = 16,
   parameter int CW = $clog2(DW)
) (
   input  logic [DW-1:0] word_i,
   output logic [CW-1:0] run_o
);
   logic [DW-2:0] same_w;
   logic [DW-2:0] pref_w;

   for (genvar i = 0; i < DW - 1; i++) begin : g_same
      assign same_w[i] = ~(word_i[i] ^ word_i[DW-1]);
   end

   assign pref_w[DW-2] = same_w[DW-2];
   for (genvar i = DW - 3; i >= 0; i--) begin : g_pref
      assign pref_w[i] = pref_w[i+1] & same_w[i];
   end

   always_comb begin
      run_o = '0;
      for (int i = 0; i < DW - 1; i++) begin
         run_o = run_o + CW'(pref_w[i]);
      end
   end

   if (DW < 4) begin : g_bad_dw
      $error("bfs_signcnt: word too narrow");
   end
   if ((DW - 1) >= (1 << CW)) begin : g_bad_cw
      $error("bfs_signcnt: count width too small");
   end

endmodule

// File: rtl/bfs_barrel.sv
module bfs_barrel #(
   parameter int RW    = 32,
   parameter int MW    = 9,
   parameter int STYLE = 0
) (
   input  logic [RW-1:0] din_i,
   input  logic          left_i,
   input  logic          arith_i,
   input  logic [MW-1:0] mag_i,
   output logic [RW-1:0] dout_o
);
   localparam int LG = $clog2(RW);
   localparam logic [MW-1:0] RW_M = MW'(RW);

   logic          fill_w;
   logic          over_w;

   assign fill_w = arith_i & ~left_i & din_i[RW-1];
   assign over_w = (mag_i >= RW_M);

   if (STYLE == 0) begin : g_staged
      logic [RW-1:0] rin_w;
      logic [RW-1:0] rout_w;
      logic [RW-1:0] stg_w [LG+1];

      for (genvar j = 0; j < RW; j++) begin : g_rev_in
         assign rin_w[j] = din_i[RW-1-j];
      end

      assign stg_w[0] = left_i ? rin_w : din_i;

      for (genvar k = 0; k < LG; k++) begin : g_stage
         localparam int STEP = 1 << k;
         assign stg_w[k+1] = mag_i[k] ? {{STEP{fill_w}}, stg_w[k][RW-1:STEP]}
                                      : stg_w[k];
      end

      for (genvar j = 0; j < RW; j++) begin : g_rev_out
         assign rout_w[j] = stg_w[LG][RW-1-j];
      end

      assign dout_o = over_w ? {RW{fill_w}} : (left_i ? rout_w : stg_w[LG]);
   end else begin : g_operator
      logic [RW-1:0] lsh_w;
      logic [RW-1:0] rsh_w;

      assign lsh_w  = din_i << mag_i;
      assign rsh_w  = arith_i ? RW'($signed(din_i) >>> mag_i) : (din_i >> mag_i);
      assign dout_o = over_w ? {RW{fill_w}} : (left_i ? lsh_w : rsh_w);
   end

   if ((1 << LG) != RW) begin : g_bad_pow2
      $error("bfs_barrel: width must be a power of two");
   end
   if (RW >= (1 << MW)) begin : g_bad_mw
      $error("bfs_barrel: magnitude width too small");
   end
   if (STYLE != 0 && STYLE != 1) begin : g_bad_style
      $error("bfs_barrel: unknown style");
   end

endmodule

// File: rtl/bfp_shifter.sv
module bfp_shifter
   import bfs_pkg::*;
#(
   parameter int DW    = 16,
   parameter int SW    = 8,
   parameter int STYLE = BFS_STYLE_STAGED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        opcode,
   input  logic [DW-1:0]     operand,
   input  logic [SW-1:0]     shamt,
   input  logic              hi_sel,
   input  logic              or_acc,
   output logic [2*DW-1:0]   result,
   output logic [SW-1:0]     exp_out
);
   localparam int RW = 2 * DW;
   localparam int MW = SW + 1;
   localparam int CW = $clog2(DW);

   logic [RW-1:0] res_q;
   logic [SW-1:0] exp_q;
   logic [CW-1:0] run_w;
   logic [SW-1:0] run_ext;
   logic [RW-1:0] field_w;
   logic [RW-1:0] shifted_w;
   logic [SW-1:0] amt_c;
   logic [MW-1:0] mag_c;
   logic          left_c;
   logic          sext_c;
   logic          arith_c;
   logic          shift_c;
   logic [SW-1:0] exp_d;
   logic [RW-1:0] res_d;

   bfs_signcnt #(.DW(DW), .CW(CW)) u_cnt (
      .word_i (operand),
      .run_o  (run_w)
   );

   assign run_ext = {{(SW-CW){1'b0}}, run_w};

   always_comb begin
      amt_c   = shamt;
      sext_c  = 1'b0;
      arith_c = 1'b0;
      shift_c = 1'b1;
      exp_d   = exp_q;
      case (opcode)
         OP_LSH: begin
            amt_c = shamt;
         end
         OP_ASH: begin
            sext_c  = 1'b1;
            arith_c = 1'b1;
         end
         OP_NORM: begin
            if (hi_sel) begin
               amt_c = run_ext;
               exp_d = SW'(0) - run_ext;
            end else begin
               amt_c = SW'(0) - exp_q;
            end
         end
         OP_DENORM: begin
            if (hi_sel) begin
               arith_c = 1'b1;
               exp_d   = shamt;
            end else begin
               amt_c = exp_q;
            end
         end
         OP_EXP: begin
            shift_c = 1'b0;
            exp_d   = SW'(0) - run_ext;
         end
         default: begin
            shift_c = 1'b0;
         end
      endcase
   end

   assign left_c = ~amt_c[SW-1];
   assign mag_c  = left_c ? {1'b0, amt_c} : (MW'(0) - {amt_c[SW-1], amt_c});

   bfs_place #(.DW(DW)) u_place (
      .word_i  (operand),
      .upper_i (hi_sel),
      .sext_i  (sext_c),
      .field_o (field_w)
   );

   bfs_barrel #(.RW(RW), .MW(MW), .STYLE(STYLE)) u_barrel (
      .din_i   (field_w),
      .left_i  (left_c),
      .arith_i (arith_c),
      .mag_i   (mag_c),
      .dout_o  (shifted_w)
   );

   assign res_d = (or_acc ? res_q : {RW{1'b0}}) | shifted_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
         exp_q <= '0;
      end else begin
         if (shift_c) begin
            res_q <= res_d;
         end
         exp_q <= exp_d;
      end
   end

   assign result  = res_q;
   assign exp_out = exp_q;

   if (CW >= SW) begin : g_bad_sw
      $error("bfp_shifter: exponent width too small for count");
   end
   if ((1 << (SW - 1)) < RW) begin : g_bad_range
      $error("bfp_shifter: shift range cannot clear the field");
   end

   // R6
   exp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == OP_EXP) |=> ($signed(exp_q) <= 0 && $signed(exp_q) > -DW));

   // R6
   exp_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == OP_EXP) |=> $stable(res_q));

   // R7
   norm_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == OP_NORM && hi_sel && !or_acc &&
       operand != {DW{1'b0}} && operand != {DW{1'b1}})
      |=> (res_q[RW-1] != res_q[RW-2]));

   // R9
   denorm_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == OP_DENORM && hi_sel) |=> (exp_q == $past(shamt)));

   // R11
   acc_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode <= 3'd3 && or_acc) |=> ((res_q & $past(res_q)) == $past(res_q)));

   // R12
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode > 3'd4) |=> ($stable(res_q) && $stable(exp_q)));

   // R13
   shift_keeps_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode <= 3'd1) |=> $stable(exp_q));

endmodule

// File: tb/tb_bfp_shifter.sv
`timescale 1ns/1ps
module tb_bfp_shifter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  opcode = 3'd7;
   logic [15:0] operand = '0;
   logic [7:0]  shamt = '0;
   logic        hi_sel = 1'b0;
   logic        or_acc = 1'b0;
   logic [31:0] result;
   logic [7:0]  exp_out;

   int n_chk = 0;
   int n_bad = 0;

   logic [31:0] m_res = '0;
   int          m_exp = 0;

   always #2 clk = ~clk;

   bfp_shifter dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .opcode  (opcode),
      .operand (operand),
      .shamt   (shamt),
      .hi_sel  (hi_sel),
      .or_acc  (or_acc),
      .result  (result),
      .exp_out (exp_out)
   );

   function automatic logic [31:0] mplace(logic [15:0] x, bit hi, bit sx);
      if (hi) return {x, 16'h0000};
      return {sx ? {16{x[15]}} : 16'h0000, x};
   endfunction

   function automatic logic [31:0] mshift(logic [31:0] p, int amt, bit ar);
      int m;
      if (amt >= 0) return (amt >= 32) ? 32'h0 : (p << amt);
      m = -amt;
      if (m >= 32) return (ar && p[31]) ? 32'hFFFF_FFFF : 32'h0;
      if (ar) return 32'($signed(p) >>> m);
      return p >> m;
   endfunction

   function automatic int mrun(logic [15:0] x);
      int n = 0;
      for (int i = 14; i >= 0; i--) begin
         if (x[i] != x[15]) break;
         n++;
      end
      return n;
   endfunction

   function automatic int s8(int v);
      int w = v & 255;
      return (w > 127) ? w - 256 : w;
   endfunction

   task automatic check(string tag, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [2:0] op, input logic [15:0] x, input int amt,
                       input bit hi, input bit acc, input string tag);
      logic [31:0] nv = '0;
      bit          sh = 1'b1;
      case (op)
         3'd0: nv = mshift(mplace(x, hi, 0), amt, 0);
         3'd1: nv = mshift(mplace(x, hi, 1), amt, 1);
         3'd2: begin
            if (hi) begin
               nv    = mshift(mplace(x, 1, 0), mrun(x), 0);
               m_exp = -mrun(x);
            end else begin
               nv = mshift(mplace(x, 0, 0), s8(-m_exp), 0);
            end
         end
         3'd3: begin
            if (hi) begin
               nv    = mshift(mplace(x, 1, 0), amt, 1);
               m_exp = s8(amt);
            end else begin
               nv = mshift(mplace(x, 0, 0), m_exp, 0);
            end
         end
         3'd4: begin
            sh    = 1'b0;
            m_exp = -mrun(x);
         end
         default: sh = 1'b0;
      endcase
      if (sh) m_res = (acc ? m_res : 32'h0) | nv;
      opcode  = op;
      operand = x;
      shamt   = 8'(amt);
      hi_sel  = hi;
      or_acc  = acc;
      @(negedge clk);
      check({tag, " result"}, result, m_res);
      check({tag, " exp"}, $signed(exp_out), m_exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
      $finish;
   end

   initial begin
      logic [15:0] vals [5] = '{16'h8001, 16'h1234, 16'hFFFF, 16'h7FFE, 16'h0001};
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 result", result, 0);
      check("R1 exp", exp_out, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release result", result, 0);
      check("R1 after release exp", exp_out, 0);

      // R2: nothing moves before the edge
      opcode = 3'd0; operand = 16'h00F0; shamt = 8'd4; hi_sel = 1'b0; or_acc = 1'b0;
      #1;
      check("R2 before edge", result, 0);
      m_res = 32'h0000_0F00;
      @(negedge clk);
      check("R2 after edge", result, m_res);

      // R3 R4 R13: logical shifts over all amounts, both placements
      foreach (vals[v]) begin
         for (int h = 0; h < 2; h++) begin
            for (int a = -128; a < 128; a++) begin
               step(3'd0, vals[v], a, h[0], 1'b0, "R4 R3 R13 lsh");
            end
         end
      end

      // R5 R3 R13: arithmetic shifts
      foreach (vals[v]) begin
         for (int h = 0; h < 2; h++) begin
            for (int a = -128; a < 128; a++) begin
               step(3'd1, vals[v], a, h[0], 1'b0, "R5 R3 R13 ash");
            end
         end
      end

      // R6: exponent of every operand
      for (int x = 0; x < 65536; x++) begin
         step(3'd4, 16'(x), x % 200 - 100, x[0], x[1], "R6 exp");
      end

      // R7 R8 R11: two-word normalize
      for (int i = 0; i < 512; i++) begin
         step(3'd2, 16'(i * 251), 0, 1'b1, 1'b0, "R7 norm hi");
         step(3'd2, 16'(i * 977 + 5), 0, 1'b0, 1'b1, "R8 R11 norm lo");
      end

      // R9 R10 R11: two-word denormalize
      for (int a = -20; a <= 0; a++) begin
         step(3'd3, 16'hC3A5, a, 1'b1, 1'b0, "R9 denorm hi");
         step(3'd3, 16'h5A5A, 0, 1'b0, 1'b1, "R10 R11 denorm lo");
         step(3'd3, 16'h4001, a, 1'b1, 1'b0, "R9 denorm hi pos");
         step(3'd3, 16'hFFFF, 0, 1'b0, 1'b1, "R10 R11 denorm lo ones");
      end

      // R11: merge of logical shifts, then replace
      step(3'd0, 16'hABCD, 16, 1'b0, 1'b0, "R11 lsh base");
      step(3'd0, 16'h1357, 0, 1'b0, 1'b1, "R11 lsh merge");
      step(3'd0, 16'h0F0F, 0, 1'b1, 1'b0, "R11 no merge");

      // R12: idle opcodes keep state
      step(3'd3, 16'h8000, -3, 1'b1, 1'b0, "R12 setup");
      for (int c = 5; c < 8; c++) begin
         step(3'(c), 16'h1234 + 16'(c), 7, c[0], c[1], "R12 idle");
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule